// File: doc/BRIEF.md
# Memory-to-memory DMA controller

This block moves data from one memory region to another without processor help. Software sets a source address, a destination address and a byte count through a small register port, then writes the control register with a transfer size and a start bit. The engine then runs a loop of single beats. Each beat reads one item through the read handshake and writes that same item through the write handshake. Each address steps by the item size unless that side is held at a fixed address. The byte count goes down by the item size after every write.

A run ends on any of three causes, and each cause has its own enable: the byte count reaching zero, a read-side end-of-packet input, or a write-side end-of-packet input. When the run ends, the engine goes idle and sets a completion flag. A level interrupt follows that flag if it is enabled. A software reset returns the whole block to its reset state, but only after two control writes in a row that both request it.

Top module: `mem_copy_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and neither memory request is asserted.
- R2: Register offsets: 0 status, 1 source address, 2 destination address, 3 byte count, 6 control, 7 a second path to the same control register. Offsets 4 and 5 read 0 and ignore writes. Status bits: 0 complete, 1 running, 2 read end-of-packet seen, 3 write end-of-packet seen, 4 count reached zero. Control bit 12 always reads 0.
- R3: A run starts only when all of these hold at the control write: control bit 3 is 1, exactly one of bits 0, 1 and 2 is set (item sizes 1, 2 and 4 bytes), bits 10 and 11 are both 0, the byte count is nonzero, and the engine is idle. Any other control write starts nothing.
- R4: `mem_rd_req` stays high until `mem_rd_ack`. Only after that does `mem_wr_req` rise, and it stays high with stable address, data and enables until `mem_wr_ack`. The two requests are never high together.
- R5: After each write beat, each address advances by the item size. Control bit 8 holds the source address fixed, and bit 9 holds the destination address fixed.
- R6: The item is taken from the byte lane chosen by the low bits of the source address. The written item is copied across the whole 32-bit bus, and the byte enables select the lane chosen by the low bits of the destination address.
- R7: After each write acknowledge, the byte count drops by the item size and saturates at 0. Status bit 4 sets when the count reaches 0.
- R8: The stop condition is checked at each write acknowledge, using three enables: bit 7 for count zero, bit 5 for read end-of-packet, bit 6 for write end-of-packet. On a stop, running clears and complete sets. With no enabled cause, the run continues.
- R9: `rd_eop` and `wr_eop` set status bits 2 and 3 in any cycle, whether or not their enables are set. A start clears status bits 0, 2, 3 and 4.
- R10: Any write to the status offset clears the complete bit.
- R11: `irq` equals complete AND control bit 4. It stays high until one of these happens: complete is cleared, the enable is cleared, or the block is reset.
- R12: While a run is active, writes to offsets 1, 2 and 3 are ignored.
- R13: A control write with bit 12 set resets the whole block, but only if the register write just before it was also a control write with bit 12 set. Any other register write in between cancels the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Write request |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |
| mem_wr_ack | input | 1 | Write acknowledge |
| rd_eop | input | 1 | Read-side end-of-packet |
| wr_eop | input | 1 | Write-side end-of-packet |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions check four things on every cycle:
- the request holding rules of each beat;
- that complete and running are never set together;
- that complete only rises on a write acknowledge, and the interrupt only falls after a register write;
- that during a run the byte count never grows and a fixed source address never moves.

Only the bench scenarios can show what a run actually produces:
- the bytes that land in memory for each size and each fixed-address combination;
- the final register values;
- which stop cause ends a run;
- that illegal sizes start nothing;
- the two-write reset sequence and its cancellation.

// File: rtl/mem_copy_dma.sv
module mem_copy_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [3:0]        mem_wr_be,
  input  logic              mem_wr_ack,
  input  logic              rd_eop,
  input  logic              wr_eop,
  output logic              irq
);

  typedef enum logic [1:0] {IDLE, RD, WR} state_t;

  state_t            st_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [LEN_W-1:0]  len_q, len_dec;
  logic [11:0]       ctrl_q;
  logic [2:0]        sz_q;
  logic [31:0]       buf_q, rd_sh;
  logic [1:0]        rd_lane;
  logic done_q, reop_q, weop_q, lenz_q, arm_q;
  logic busy, wr_ctrl, sw_reset, size_ok, start, stop, len_end;
  logic unused_bits;

  assign unused_bits = ^reg_wdata[31:13];

  assign busy     = st_q != IDLE;
  assign wr_ctrl  = reg_wr && (reg_sel == 3'd6 || reg_sel == 3'd7);
  assign sw_reset = wr_ctrl && reg_wdata[12] && arm_q;
  assign size_ok  = ($countones(reg_wdata[2:0]) == 1) && (reg_wdata[11:10] == 2'b00);
  assign start    = wr_ctrl && !sw_reset && reg_wdata[3] && size_ok && (len_q != '0) && !busy;

  assign len_dec = (len_q > LEN_W'(sz_q)) ? len_q - LEN_W'(sz_q) : '0;
  assign len_end = len_dec == '0;
  assign stop    = (ctrl_q[5] && (reop_q || rd_eop)) ||
                   (ctrl_q[6] && (weop_q || wr_eop)) ||
                   (ctrl_q[7] && len_end);

  assign rd_lane = sz_q[2] ? 2'b00 : sz_q[1] ? {rd_addr_q[1], 1'b0} : rd_addr_q[1:0];
  assign rd_sh   = mem_rd_data >> {rd_lane, 3'b000};

  assign mem_rd_req  = st_q == RD;
  assign mem_rd_addr = rd_addr_q;
  assign mem_wr_req  = st_q == WR;
  assign mem_wr_addr = wr_addr_q;
  assign mem_wr_data = sz_q[2] ? buf_q : sz_q[1] ? {2{buf_q[15:0]}} : {4{buf_q[7:0]}};
  assign mem_wr_be   = sz_q[2] ? 4'hF :
                       sz_q[1] ? (wr_addr_q[1] ? 4'hC : 4'h3) :
                       (4'h1 << wr_addr_q[1:0]);
  assign irq = done_q && ctrl_q[4];

  always_comb begin
    case (reg_sel)
      3'd0:       reg_rdata = {27'd0, lenz_q, weop_q, reop_q, busy, done_q};
      3'd1:       reg_rdata = 32'(rd_addr_q);
      3'd2:       reg_rdata = 32'(wr_addr_q);
      3'd3:       reg_rdata = 32'(len_q);
      3'd6, 3'd7: reg_rdata = {20'd0, ctrl_q};
      default:    reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IDLE;  rd_addr_q <= '0; wr_addr_q <= '0; len_q <= '0;
      ctrl_q <= '0;  sz_q <= '0;      buf_q <= '0;
      done_q <= 1'b0; reop_q <= 1'b0; weop_q <= 1'b0; lenz_q <= 1'b0; arm_q <= 1'b0;
    end else if (sw_reset) begin
      st_q <= IDLE;  rd_addr_q <= '0; wr_addr_q <= '0; len_q <= '0;
      ctrl_q <= '0;  sz_q <= '0;      buf_q <= '0;
      done_q <= 1'b0; reop_q <= 1'b0; weop_q <= 1'b0; lenz_q <= 1'b0; arm_q <= 1'b0;
    end else begin
      if (reg_wr) arm_q <= wr_ctrl && reg_wdata[12];
      if (rd_eop) reop_q <= 1'b1;
      if (wr_eop) weop_q <= 1'b1;
      if (reg_wr) begin
        case (reg_sel)
          3'd0:       done_q <= 1'b0;
          3'd1:       if (!busy) rd_addr_q <= reg_wdata[ADDR_W-1:0];
          3'd2:       if (!busy) wr_addr_q <= reg_wdata[ADDR_W-1:0];
          3'd3:       if (!busy) len_q <= reg_wdata[LEN_W-1:0];
          3'd6, 3'd7: ctrl_q <= reg_wdata[11:0];
          default:    ;
        endcase
      end
      if (start) begin
        st_q   <= RD;
        sz_q   <= reg_wdata[2] ? 3'd4 : reg_wdata[1] ? 3'd2 : 3'd1;
        done_q <= 1'b0;
        reop_q <= 1'b0;
        weop_q <= 1'b0;
        lenz_q <= 1'b0;
      end
      case (st_q)
        RD: if (mem_rd_ack) begin
          buf_q <= sz_q[2] ? rd_sh : sz_q[1] ? {16'd0, rd_sh[15:0]} : {24'd0, rd_sh[7:0]};
          st_q  <= WR;
        end
        WR: if (mem_wr_ack) begin
          len_q <= len_dec;
          if (!ctrl_q[8]) rd_addr_q <= rd_addr_q + ADDR_W'(sz_q);
          if (!ctrl_q[9]) wr_addr_q <= wr_addr_q + ADDR_W'(sz_q);
          if (len_end) lenz_q <= 1'b1;
          if (stop) begin
            st_q   <= IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= RD;
          end
        end
        default: ;
      endcase
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack && !reg_wr) |=> mem_rd_req);

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack && !reg_wr) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be)));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(mem_wr_ack));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));

  // R12
  len_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (len_q <= $past(len_q)));

  // R5
  rd_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_q[8]) |=> $stable(rd_addr_q));

endmodule

// File: tb/mem_copy_dma_tb.sv
`timescale 1ns/1ps
module mem_copy_dma_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        mem_rd_ack, mem_wr_ack;
  logic [31:0] mem_rd_data;
  logic        rd_eop = 0, wr_eop = 0;
  logic        irq;

  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int n_tests = 0, n_fail = 0, both_cnt = 0;

  always #10 clk = ~clk;

  mem_copy_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .mem_wr_ack(mem_wr_ack), .rd_eop(rd_eop), .wr_eop(wr_eop), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_ack <= 0; mem_wr_ack <= 0; mem_rd_data <= 0;
    end else begin
      mem_rd_ack <= mem_rd_req && !mem_rd_ack;
      if (mem_rd_req && !mem_rd_ack)
        mem_rd_data <= {mem[{mem_rd_addr[7:2], 2'd3}], mem[{mem_rd_addr[7:2], 2'd2}],
                        mem[{mem_rd_addr[7:2], 2'd1}], mem[{mem_rd_addr[7:2], 2'd0}]};
      mem_wr_ack <= mem_wr_req && !mem_wr_ack;
      if (mem_wr_req && !mem_wr_ack)
        for (int k = 0; k < 4; k++)
          if (mem_wr_be[k]) mem[{mem_wr_addr[7:2], 2'(k)}] <= mem_wr_data[8*k +: 8];
    end
  end

  always @(negedge clk) if (mem_rd_req && mem_wr_req) both_cnt++;

  // {size code, src fixed, dst fixed, src, dst, len}
  localparam logic [27:0] VECS [8] = '{
    {2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 8'd5},
    {2'd1, 1'b0, 1'b0, 8'h04, 8'h92, 8'd6},
    {2'd2, 1'b0, 1'b0, 8'h10, 8'hA0, 8'd12},
    {2'd0, 1'b1, 1'b0, 8'h03, 8'hB0, 8'd4},
    {2'd2, 1'b0, 1'b1, 8'h20, 8'hC0, 8'd8},
    {2'd1, 1'b0, 1'b0, 8'h30, 8'hD2, 8'd3},
    {2'd0, 1'b0, 1'b0, 8'h41, 8'hE3, 8'd3},
    {2'd1, 1'b1, 1'b1, 8'h52, 8'hF0, 8'd4}
  };

  function automatic logic [7:0] init_val(int i);
    return (i < 128) ? 8'(i * 7 + 3) : 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] s, logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic init_mem();
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      mem[i] <= init_val(i);
      expm[i] = init_val(i);
    end
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      rd_reg(3'd0, s);
      ok = s[0];
    end
  endtask

  task automatic run_vec(int vi);
    logic [27:0] v;
    int szc, sz, src, dst, len, beats, rcon, wcon, bad;
    logic [31:0] r;
    bit ok;
    v = VECS[vi];
    szc = int'(v[27:26]); rcon = int'(v[25]); wcon = int'(v[24]);
    src = int'(v[23:16]); dst = int'(v[15:8]); len = int'(v[7:0]);
    sz = 1 << szc;
    beats = (len + sz - 1) / sz;
    init_mem();
    for (int b = 0; b < beats; b++)
      for (int k = 0; k < sz; k++)
        expm[((wcon != 0) ? dst : dst + b * sz) + k] = init_val(((rcon != 0) ? src : src + b * sz) + k);
    wr_reg(3'd1, 32'(src));
    wr_reg(3'd2, 32'(dst));
    wr_reg(3'd3, 32'(len));
    wr_reg(3'd6, 32'(sz) | 32'h88 | (32'(rcon) << 8) | (32'(wcon) << 9));
    wait_done(ok);
    chk($sformatf("R8 vector %0d completes", vi), 32'(ok), 32'd1);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
    chk($sformatf("R6 vector %0d memory image mismatches", vi), 32'(bad), 32'd0);
    rd_reg(3'd3, r); chk($sformatf("R7 vector %0d count", vi), r, 32'd0);
    rd_reg(3'd0, r); chk($sformatf("R8 vector %0d status", vi), r, 32'h11);
    rd_reg(3'd1, r); chk($sformatf("R5 vector %0d src addr", vi), r, 32'((rcon != 0) ? src : src + beats * sz));
    rd_reg(3'd2, r); chk($sformatf("R5 vector %0d dst addr", vi), r, 32'((wcon != 0) ? dst : dst + beats * sz));
    wr_reg(3'd0, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1
    rd_reg(3'd0, r); chk("R1 status", r, 0);
    rd_reg(3'd1, r); chk("R1 src", r, 0);
    rd_reg(3'd2, r); chk("R1 dst", r, 0);
    rd_reg(3'd3, r); chk("R1 count", r, 0);
    rd_reg(3'd6, r); chk("R1 control", r, 0);
    chk("R1 irq and requests", {29'd0, irq, mem_rd_req, mem_wr_req}, 0);

    // R2
    wr_reg(3'd1, 32'h1234_5678); rd_reg(3'd1, r); chk("R2 src readback", r, 32'h1234_5678);
    wr_reg(3'd5, 32'hFFFF);      rd_reg(3'd5, r); chk("R2 offset 5 reads 0", r, 0);
    rd_reg(3'd4, r); chk("R2 offset 4 reads 0", r, 0);
    wr_reg(3'd7, 32'h0000_1310); rd_reg(3'd6, r); chk("R2 alias write seen at 6", r, 32'h310);
    rd_reg(3'd7, r); chk("R2 alias read", r, 32'h310);
    wr_reg(3'd6, 32'd0);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R3
    init_mem();
    wr_reg(3'd1, 0); wr_reg(3'd2, 32'h80); wr_reg(3'd3, 4);
    wr_reg(3'd6, 32'h488);
    repeat (10) @(negedge clk);
    rd_reg(3'd0, r); chk("R3 double-word size ignored", r[1:0], 0);
    wr_reg(3'd6, 32'h08B);
    repeat (10) @(negedge clk);
    rd_reg(3'd0, r); chk("R3 two size bits ignored", r[1:0], 0);
    rd_reg(3'd3, r); chk("R3 count untouched", r, 4);
    chk("R3 no memory write", 32'(mem[8'h80]), 0);
    wr_reg(3'd3, 0); wr_reg(3'd6, 32'h089);
    repeat (10) @(negedge clk);
    rd_reg(3'd0, r); chk("R3 zero count ignored", r[1:0], 0);

    // R11 R10
    wr_reg(3'd3, 4); wr_reg(3'd6, 32'h099);
    wait_done(ok);
    #1 chk("R11 irq on completion", 32'(irq), 1);
    repeat (5) @(negedge clk);
    #1 chk("R11 irq persists", 32'(irq), 1);
    wr_reg(3'd0, 0);
    #1 chk("R11 irq drops after clear", 32'(irq), 0);
    rd_reg(3'd0, r); chk("R10 status write clears complete", r, 32'h10);

    // R8 read end-of-packet
    init_mem();
    wr_reg(3'd1, 0); wr_reg(3'd2, 32'h80); wr_reg(3'd3, 16);
    @(negedge clk); rd_eop = 1;
    wr_reg(3'd6, 32'h029);
    wait_done(ok);
    rd_eop = 0;
    rd_reg(3'd3, r); chk("R8 read eop stops after one beat", r, 15);
    rd_reg(3'd0, r); chk("R8 read eop status", r, 32'h05);
    chk("R11 irq off when disabled", 32'(irq), 0);
    wr_reg(3'd0, 0);

    // R9 R8 R7 R12 R13
    wr_reg(3'd1, 0); wr_reg(3'd2, 32'h80); wr_reg(3'd3, 2);
    wr_reg(3'd6, 32'h009);
    repeat (40) @(negedge clk);
    wr_eop = 1; @(negedge clk); wr_eop = 0;
    rd_reg(3'd0, r); chk("R9 write eop recorded, R8 run continues", r, 32'h1A);
    rd_reg(3'd3, r); chk("R7 count saturates at zero", r, 0);
    wr_reg(3'd3, 32'h55);
    rd_reg(3'd3, r); chk("R12 count write ignored while running", r, 0);
    wr_reg(3'd6, 32'h1000); wr_reg(3'd0, 0); wr_reg(3'd6, 32'h1000);
    rd_reg(3'd0, r); chk("R13 interrupted sequence no reset", r[1], 1);
    wr_reg(3'd6, 32'h1000);
    rd_reg(3'd0, r); chk("R13 reset status", r, 0);
    rd_reg(3'd1, r); chk("R13 reset src", r, 0);
    rd_reg(3'd6, r); chk("R13 reset control", r, 0);
    repeat (4) @(negedge clk);
    chk("R13 no requests after reset", {30'd0, mem_rd_req, mem_wr_req}, 0);

    chk("R4 requests never overlap", 32'(both_cnt), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule